// File: doc/BRIEF.md
# Two's Complement Add/Subtract Unit with Overflow and True-Sign Flags

This block is a purely combinational adder/subtractor for signed two's complement operands of a configurable width. A single control input chooses between sum and difference. To subtract, the block inverts every bit of the right-hand operand and feeds the control bit in as the carry into bit zero, so one carry network serves both operations. The carry network is chosen by parameter: a ripple chain or a logarithmic-depth parallel prefix tree.

The block has three outputs. The first is the wrapped result of the chosen width. The second is an overflow flag, raised when the exact signed answer does not fit that width. The third is a sign flag. It reports whether the exact mathematical answer is negative, and it stays correct when overflow has occurred. Because of this, a compare-and-branch built on the sign flag still gives the right decision after an overflowing operation.

Both flags come from carries the network already computes. Overflow is the XOR of the carry into the top bit and the carry out of it. The sign flag is the XOR of the top-bit propagate term and the carry out of the top bit. Together these equal bit W of a sum extended by one bit.

Top module: `addsub_unit`

## Requirements
- R1: With `do_sub` = 0, `total` equals (`lhs` + `rhs`) modulo 2^WIDTH.
- R2: With `do_sub` = 1, `total` equals (`lhs` - `rhs`) modulo 2^WIDTH. This is formed as `lhs` + (bitwise NOT `rhs`) + 1.
- R3: `ovf_flag` is 1 exactly when the exact signed result, with both operands read as two's complement, lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R4: Two cases never raise `ovf_flag`: adding operands whose top bits differ, and subtracting operands whose top bits are equal.
- R5: `neg_flag` is 1 exactly when the exact signed result is below zero. This holds whether or not overflow occurred.
- R6: When `ovf_flag` is 1, `total` still carries the low WIDTH bits of the exact result. The wrapped value is never replaced or clamped.
- R7: `neg_flag` XOR `total[WIDTH-1]` equals `ovf_flag`. The sign flag matches the result's top bit without overflow and is its inverse with overflow.
- R8: At WIDTH 4, adding 4'b0111 and 4'b0001 gives `total` = 4'b1000, `ovf_flag` = 1 and `neg_flag` = 0, because the exact answer is +8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lhs | input | WIDTH | Left operand, two's complement |
| rhs | input | WIDTH | Right operand, two's complement |
| do_sub | input | 1 | 0 selects lhs+rhs, 1 selects lhs-rhs |
| total | output | WIDTH | Wrapped result, low WIDTH bits of the exact value |
| ovf_flag | output | 1 | Exact result not representable in WIDTH bits |
| neg_flag | output | 1 | Exact result is negative, valid under overflow |

## Verification
All three outputs are due in the same cycle as the operands, with zero register stages between ports. The bench therefore changes operands on a falling clock edge and samples `total`, `ovf_flag` and `neg_flag` one nanosecond later, well before the next rising edge, so every comparison sees settled combinational values. Expected values come from exact integer arithmetic on sign-extended operands. The bench sweeps every input combination at widths 4 (ripple network) and 6 (prefix network), and checks mixed random and boundary operands at width 32.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;

    // Carry structure chosen for the internal adder.
    typedef enum logic {
        CARRY_RIPPLE = 1'b0,
        CARRY_PREFIX = 1'b1
    } carry_style_e;

endpackage

// File: rtl/addsub_operand_prep.sv
`timescale 1ns/1ps
module addsub_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rhs_raw,
    input  logic             invert,
    output logic [WIDTH-1:0] rhs_eff
);

    // Conditional ones' complement; the +1 of negation enters as carry-in.
    assign rhs_eff = rhs_raw ^ {WIDTH{invert}};

    always_comb begin
        p_invert_rule_r2 : assert (invert ? (rhs_eff == ~rhs_raw) : (rhs_eff == rhs_raw))
            else $error("operand conditioning mismatch");
    end

endmodule

// File: rtl/addsub_carry_net.sv
`timescale 1ns/1ps
module addsub_carry_net
    import addsub_pkg::*;
#(
    parameter int           WIDTH = 32,
    parameter carry_style_e STYLE = CARRY_PREFIX
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_into_msb,
    output logic             c_out
);

    localparam int LVLS = $clog2(WIDTH);

    // carries[i] is the carry into bit i; carries[WIDTH] leaves the top bit.
    logic [WIDTH:0] carries;

    assign carries[0] = cin;

    generate
        if (STYLE == CARRY_RIPPLE) begin : g_ripple
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign carries[i+1] = (x[i] & y[i]) | ((x[i] ^ y[i]) & carries[i]);
            end
        end else begin : g_prefix
            // Group generate/propagate per tree level; level 0 folds cin into bit 0.
            logic [WIDTH-1:0] grp_g [0:LVLS];
            logic [WIDTH-1:0] grp_p [0:LVLS];

            for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
                if (i == 0) begin : g_lsb
                    assign grp_g[0][i] = (x[i] & y[i]) | ((x[i] ^ y[i]) & cin);
                end else begin : g_other
                    assign grp_g[0][i] = x[i] & y[i];
                end
                assign grp_p[0][i] = x[i] ^ y[i];
            end

            for (genvar k = 0; k < LVLS; k++) begin : g_level
                localparam int DIST = 1 << k;
                for (genvar i = 0; i < WIDTH; i++) begin : g_node
                    if (i >= DIST) begin : g_merge
                        assign grp_g[k+1][i] = grp_g[k][i] | (grp_p[k][i] & grp_g[k][i-DIST]);
                        assign grp_p[k+1][i] = grp_p[k][i] & grp_p[k][i-DIST];
                    end else begin : g_pass
                        assign grp_g[k+1][i] = grp_g[k][i];
                        assign grp_p[k+1][i] = grp_p[k][i];
                    end
                end
            end

            for (genvar i = 0; i < WIDTH; i++) begin : g_carry
                assign carries[i+1] = grp_g[LVLS][i];
            end
        end
    endgenerate

    assign sum        = x ^ y ^ carries[WIDTH-1:0];
    assign c_into_msb = carries[WIDTH-1];
    assign c_out      = carries[WIDTH];

    // The carry network must agree with plain binary addition.
    always_comb begin
        p_sum_exact_r1 : assert ({c_out, sum} ==
                                 ({1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin}))
            else $error("carry network sum mismatch");
    end

endmodule

// File: rtl/addsub_flag_gen.sv
`timescale 1ns/1ps
module addsub_flag_gen (
    input  logic x_msb,
    input  logic y_msb,
    input  logic sum_msb,
    input  logic c_into_msb,
    input  logic c_out,
    output logic ovf,
    output logic neg
);

    logic top_prop;

    assign top_prop = x_msb ^ y_msb;
    assign ovf      = c_out ^ c_into_msb;
    // Bit WIDTH of the one-bit sign-extended sum.
    assign neg      = top_prop ^ c_out;

    always_comb begin
        // Overflow only when like-signed operands give an other-signed result.
        p_ovf_sign_rule_r3 : assert (ovf == ((x_msb == y_msb) && (sum_msb != x_msb)))
            else $error("overflow flag disagrees with sign rule");
        if (x_msb != y_msb) begin
            p_no_overflow_r4 : assert (!ovf)
                else $error("overflow on opposite-signed operands");
        end
        if (ovf) begin
            p_neg_under_ovf_r5 : assert (neg == x_msb)
                else $error("true sign wrong under overflow");
        end
        p_neg_vs_msb_r7 : assert ((neg ^ sum_msb) == ovf)
            else $error("sign flag inconsistent with result msb");
    end

endmodule

// File: rtl/addsub_unit.sv
`timescale 1ns/1ps
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int           WIDTH       = 32,
    parameter carry_style_e CARRY_STYLE = CARRY_PREFIX
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic             do_sub,
    output logic [WIDTH-1:0] total,
    output logic             ovf_flag,
    output logic             neg_flag
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] rhs_eff;
    logic [WIDTH-1:0] raw_sum;
    logic             c_top_in;
    logic             c_top_out;

    addsub_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .rhs_raw (rhs),
        .invert  (do_sub),
        .rhs_eff (rhs_eff)
    );

    addsub_carry_net #(.WIDTH(WIDTH), .STYLE(CARRY_STYLE)) u_net (
        .x          (lhs),
        .y          (rhs_eff),
        .cin        (do_sub),
        .sum        (raw_sum),
        .c_into_msb (c_top_in),
        .c_out      (c_top_out)
    );

    addsub_flag_gen u_flags (
        .x_msb      (lhs[MSB]),
        .y_msb      (rhs_eff[MSB]),
        .sum_msb    (raw_sum[MSB]),
        .c_into_msb (c_top_in),
        .c_out      (c_top_out),
        .ovf        (ovf_flag),
        .neg        (neg_flag)
    );

    // Wrapped value passes through untouched, overflow or not.
    assign total = raw_sum;

    always_comb begin
        p_wrap_kept_r6 : assert (total == (do_sub ? (lhs - rhs) : (lhs + rhs)))
            else $error("result not equal to wrapped arithmetic");
    end

endmodule

// File: tb/tb_addsub_unit.sv
`timescale 1ns/1ps
module tb_addsub_unit;
    import addsub_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Width 32, prefix network
    logic [31:0] a32, b32, r32;
    logic        op32, o32, n32;
    // Width 6, prefix network
    logic [5:0]  a6, b6, r6;
    logic        op6, o6, n6;
    // Width 4, ripple network
    logic [3:0]  a4, b4, r4;
    logic        op4, o4, n4;

    addsub_unit #(.WIDTH(32), .CARRY_STYLE(CARRY_PREFIX)) dut (
        .lhs(a32), .rhs(b32), .do_sub(op32),
        .total(r32), .ovf_flag(o32), .neg_flag(n32));

    addsub_unit #(.WIDTH(6), .CARRY_STYLE(CARRY_PREFIX)) u_w6 (
        .lhs(a6), .rhs(b6), .do_sub(op6),
        .total(r6), .ovf_flag(o6), .neg_flag(n6));

    addsub_unit #(.WIDTH(4), .CARRY_STYLE(CARRY_RIPPLE)) u_w4 (
        .lhs(a4), .rhs(b4), .do_sub(op4),
        .total(r4), .ovf_flag(o4), .neg_flag(n4));

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic longint sext(int w, longint v);
        longint m = (longint'(1) << w) - 1;
        longint t = v & m;
        return ((t >> (w - 1)) & 1) != 0 ? t - (longint'(1) << w) : t;
    endfunction

    // Compare sampled outputs with exact signed arithmetic.
    task automatic score(int w, longint a, longint b, bit op,
                         longint res, bit ovf, bit neg);
        longint sa    = sext(w, a);
        longint sb    = sext(w, b);
        longint exact = op ? sa - sb : sa + sb;
        longint lim   = longint'(1) << (w - 1);
        longint mask  = (longint'(1) << w) - 1;
        longint eres  = exact & mask;
        bit     eovf  = (exact >= lim) || (exact < -lim);
        bit     eneg  = exact < 0;
        bit     amsb  = ((a >> (w - 1)) & 1) != 0;
        bit     bmsb  = ((b >> (w - 1)) & 1) != 0;
        bit     rmsb  = ((res >> (w - 1)) & 1) != 0;
        chk(op ? "R2 result" : "R1 result", res, eres);
        chk("R3 ovf", ovf, eovf);
        chk("R5 neg", neg, eneg);
        if ((!op && amsb != bmsb) || (op && amsb == bmsb))
            chk("R4 no ovf", ovf, 0);
        if (eovf)
            chk("R6 wrapped", res, eres);
        chk("R7 neg^msb", neg ^ rmsb, eovf);
    endtask

    task automatic run32(logic [31:0] a, logic [31:0] b, bit op);
        @(negedge clk);
        a32 = a; b32 = b; op32 = op;
        #1;
        score(32, longint'(a), longint'(b), op, longint'(r32), o32, n32);
    endtask

    task automatic run6(logic [5:0] a, logic [5:0] b, bit op);
        @(negedge clk);
        a6 = a; b6 = b; op6 = op;
        #1;
        score(6, longint'(a), longint'(b), op, longint'(r6), o6, n6);
    endtask

    task automatic run4(logic [3:0] a, logic [3:0] b, bit op);
        @(negedge clk);
        a4 = a; b4 = b; op4 = op;
        #1;
        score(4, longint'(a), longint'(b), op, longint'(r4), o4, n4);
    endtask

    function automatic logic [31:0] pick32();
        logic [31:0] corner [5] = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff};
        if ($urandom_range(0, 3) == 0) return corner[$urandom_range(0, 4)];
        return $urandom();
    endfunction

    initial begin
        void'($urandom(32'd4242));
        a32 = '0; b32 = '0; op32 = 1'b0;
        a6  = '0; b6  = '0; op6  = 1'b0;
        a4  = '0; b4  = '0; op4  = 1'b0;
        #1;
        // Idle inputs: all outputs zero (R1)
        chk("R1 idle result", longint'(r32), 0);
        chk("R3 idle ovf", o32, 0);
        chk("R5 idle neg", n32, 0);

        // R8 directed: 0111 + 0001 at width 4
        @(negedge clk);
        a4 = 4'b0111; b4 = 4'b0001; op4 = 1'b0;
        #1;
        chk("R8 result", longint'(r4), 8);
        chk("R8 ovf", o4, 1);
        chk("R8 neg", n4, 0);

        // Directed corners at width 32
        run32(32'h7fff_ffff, 32'h0000_0001, 1'b0); // positive overflow
        run32(32'h8000_0000, 32'hffff_ffff, 1'b0); // negative overflow
        run32(32'h8000_0000, 32'h0000_0001, 1'b1); // min - 1
        run32(32'h0000_0000, 32'h8000_0000, 1'b1); // 0 - min
        run32(32'h7fff_ffff, 32'h8000_0000, 1'b1); // max - min
        run32(32'h8000_0000, 32'h8000_0000, 1'b1); // min - min
        run32(32'hffff_ffff, 32'h0000_0001, 1'b0); // -1 + 1

        // Exhaustive widths 4 (ripple) and 6 (prefix)
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int op = 0; op < 2; op++)
                    run4(4'(a), 4'(b), 1'(op));
        for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++)
                for (int op = 0; op < 2; op++)
                    run6(6'(a), 6'(b), 1'(op));

        // Random mixed with corner operands at width 32
        for (int n = 0; n < 3000; n++)
            run32(pick32(), pick32(), 1'($urandom_range(0, 1)));

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule